// File: doc/BRIEF.md
# Per-Channel Telemetry Extreme Tracker

This block keeps running extremes of telemetry samples for a bank of power channels and a bank of temperature channels. For every power channel it holds the highest voltage seen, the lowest voltage seen and the highest current seen. For every temperature channel it holds the highest temperature seen. Temperature samples are unsigned 16-bit values in hundredths of a degree, so a reading of 2500 means 25.00 degrees.

Samples arrive on a valid/ready stream. The stream carries a channel index, a voltage, a current and a temperature. Power channels use indices 0 to NUM_PWR-1. Temperature channels follow at NUM_PWR to NUM_PWR+NUM_TEMP-1. The sink never applies back-pressure: `samp_ready` is held high, and a sample is consumed in every cycle where `samp_valid` is high. A power sample whose voltage is exactly zero marks a supply that is switched off, and it is dropped.

A host port reads any stored extreme and can overwrite it, for example to clear it between measurement windows. The port has one address, a write enable, write data and registered read data.

Top module: `telem_extreme_tracker`

## Requirements
- R1: After reset, every voltage peak, current peak and temperature peak reads 0, every voltage minimum reads 0x7FFF, and `host_rdata` is 0.
- R2: A consumed sample for a power channel whose voltage is zero changes none of that channel's three registers, including its current peak.
- R3: For a non-zero voltage sample, a power channel's voltage peak is replaced when the sample is strictly greater, compared as unsigned 16-bit (0x8000 exceeds 0x7FFF).
- R4: For a non-zero voltage sample, a power channel's voltage minimum is replaced when the sample is strictly smaller, compared as unsigned 16-bit.
- R5: A power channel's current peak is replaced when the current sample is strictly greater and the voltage sample of the same beat is non-zero.
- R6: A sample whose index is NUM_PWR+k updates temperature peak k when `samp_temp` is strictly greater; its voltage and current fields are ignored, including a zero voltage.
- R7: A host write overwrites the addressed register. When a sample update hits the same register in the same cycle, the host write wins.
- R8: The address field layout is fixed. `host_addr[5:4]` selects the kind: 0 is voltage peak, 1 is voltage minimum, 2 is current peak and 3 is temperature peak. `host_addr[3:0]` selects the channel. `host_rdata` in the cycle after an address is presented shows the register value from before that cycle's updates, so a write and a read to one address in the same cycle return the old value.
- R9: A temperature-peak address with channel NUM_TEMP or above reads 0, and a write to it has no effect. A sample whose index is NUM_PWR+NUM_TEMP or above changes no register.
- R10: `samp_ready` is high in every cycle after reset. Every extreme update becomes visible one clock after the beat in which the sample is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_valid | input | 1 | Sample beat present |
| samp_ready | output | 1 | Sink ready, held high |
| samp_chan | input | 5 | Channel index: power first, then temperature |
| samp_volt | input | 16 | Voltage sample, unsigned |
| samp_curr | input | 16 | Current sample, unsigned |
| samp_temp | input | 16 | Temperature sample, hundredths of a degree |
| host_addr | input | 6 | Kind in [5:4], channel in [3:0] |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data, one clock latency |

## Verification
The bench builds the block with its default parameters: 16 power channels, 5 temperature channels and 16-bit samples. With these values the 5-bit sample index has eleven unused codes above the temperature range. The temperature kind has eleven unused channel addresses. Both gaps are driven so that the ignore rules can be checked. The 16-bit width puts the sign-bit boundary (0x7FFF against 0x8000) and the 0x7FFF minimum start value in range for the unsigned-compare checks.

// File: rtl/telem_pkg.sv
package telem_pkg;

  // Kind field of the host address; the bench and the decoder share this order
  typedef enum logic [1:0] {
    KIND_VPEAK = 2'd0,
    KIND_VMIN  = 2'd1,
    KIND_IPEAK = 2'd2,
    KIND_TPEAK = 2'd3
  } ext_kind_e;

  localparam int KIND_W = 2;

endpackage

// File: rtl/telem_pwr_lane.sv
module telem_pwr_lane #(
  parameter int DW    = 16,
  parameter int SCH_W = 5,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_fire,
  input  logic [SCH_W-1:0] samp_chan,
  input  logic [DW-1:0]    samp_volt,
  input  logic [DW-1:0]    samp_curr,
  input  logic             wr_vpeak,
  input  logic             wr_vmin,
  input  logic             wr_ipeak,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    vpeak,
  output logic [DW-1:0]    vmin,
  output logic [DW-1:0]    ipeak
);

  localparam logic [DW-1:0] VMIN_INIT = {1'b0, {(DW-1){1'b1}}};

  logic mine;
  logic live;
  assign mine = samp_fire && (samp_chan == SCH_W'(IDX));
  assign live = mine && (samp_volt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpeak <= '0;
      vmin  <= VMIN_INIT;
      ipeak <= '0;
    end else begin
      if (wr_vpeak)                       vpeak <= wdata;
      else if (live && samp_volt > vpeak) vpeak <= samp_volt;

      if (wr_vmin)                        vmin  <= wdata;
      else if (live && samp_volt < vmin)  vmin  <= samp_volt;

      if (wr_ipeak)                       ipeak <= wdata;
      else if (live && samp_curr > ipeak) ipeak <= samp_curr;
    end
  end

  // R2
  zero_volt_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mine && samp_volt == '0 && !wr_vpeak && !wr_vmin && !wr_ipeak)
      |=> ($stable(vpeak) && $stable(vmin) && $stable(ipeak)));

  // R3
  vpeak_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vpeak |=> vpeak >= $past(vpeak));

  // R4
  vmin_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vmin |=> vmin <= $past(vmin));

  // R5
  ipeak_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ipeak |=> ipeak >= $past(ipeak));

  // R7
  host_over_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vpeak && live) |=> vpeak == $past(wdata));

endmodule

// File: rtl/telem_temp_lane.sv
module telem_temp_lane #(
  parameter int DW    = 16,
  parameter int SCH_W = 5,
  parameter int IDX   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_fire,
  input  logic [SCH_W-1:0] samp_chan,
  input  logic [DW-1:0]    samp_temp,
  input  logic             wr_tpeak,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    tpeak
);

  logic mine;
  assign mine = samp_fire && (samp_chan == SCH_W'(IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         tpeak <= '0;
    else if (wr_tpeak)                  tpeak <= wdata;
    else if (mine && samp_temp > tpeak) tpeak <= samp_temp;
  end

  // R6
  tpeak_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_tpeak |=> tpeak >= $past(tpeak));

  // R6
  tpeak_other_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mine && !wr_tpeak) |=> $stable(tpeak));

endmodule

// File: rtl/telem_host_port.sv
module telem_host_port
  import telem_pkg::*;
#(
  parameter int DW       = 16,
  parameter int NUM_PWR  = 16,
  parameter int NUM_TEMP = 5,
  parameter int CH_W     = 4,
  parameter int AW       = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [AW-1:0]                    host_addr,
  input  logic                             host_we,
  input  logic [DW-1:0]                    host_wdata,
  input  logic [NUM_PWR-1:0][DW-1:0]       vpeak_a,
  input  logic [NUM_PWR-1:0][DW-1:0]       vmin_a,
  input  logic [NUM_PWR-1:0][DW-1:0]       ipeak_a,
  input  logic [NUM_TEMP-1:0][DW-1:0]      tpeak_a,
  output logic [NUM_PWR-1:0]               wr_vpeak,
  output logic [NUM_PWR-1:0]               wr_vmin,
  output logic [NUM_PWR-1:0]               wr_ipeak,
  output logic [NUM_TEMP-1:0]              wr_tpeak,
  output logic [DW-1:0]                    host_rdata
);

  ext_kind_e         kind;
  logic [CH_W-1:0]   ch;
  logic [DW-1:0]     rd_next;

  assign kind = ext_kind_e'(host_addr[AW-1 -: KIND_W]);
  assign ch   = host_addr[CH_W-1:0];

  for (genvar gp = 0; gp < NUM_PWR; gp++) begin : g_pwr_dec
    assign wr_vpeak[gp] = host_we && kind == KIND_VPEAK && ch == CH_W'(gp);
    assign wr_vmin[gp]  = host_we && kind == KIND_VMIN  && ch == CH_W'(gp);
    assign wr_ipeak[gp] = host_we && kind == KIND_IPEAK && ch == CH_W'(gp);
  end

  for (genvar gt = 0; gt < NUM_TEMP; gt++) begin : g_temp_dec
    assign wr_tpeak[gt] = host_we && kind == KIND_TPEAK && ch == CH_W'(gt);
  end

  always_comb begin
    rd_next = '0;
    unique case (kind)
      KIND_VPEAK: if (int'(ch) < NUM_PWR)  rd_next = vpeak_a[ch];
      KIND_VMIN:  if (int'(ch) < NUM_PWR)  rd_next = vmin_a[ch];
      KIND_IPEAK: if (int'(ch) < NUM_PWR)  rd_next = ipeak_a[ch];
      KIND_TPEAK: if (int'(ch) < NUM_TEMP) rd_next = tpeak_a[ch];
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else        host_rdata <= rd_next;
  end

  // R8
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_vpeak, wr_vmin, wr_ipeak, wr_tpeak}));

  // R9
  no_write_without_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_we |-> ({wr_vpeak, wr_vmin, wr_ipeak, wr_tpeak} == '0));

endmodule

// File: rtl/telem_extreme_tracker.sv
module telem_extreme_tracker #(
  parameter int DW       = 16,
  parameter int NUM_PWR  = 16,
  parameter int NUM_TEMP = 5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 samp_valid,
  output logic                                 samp_ready,
  input  logic [$clog2(NUM_PWR+NUM_TEMP)-1:0]  samp_chan,
  input  logic [DW-1:0]                        samp_volt,
  input  logic [DW-1:0]                        samp_curr,
  input  logic [DW-1:0]                        samp_temp,
  input  logic [$clog2(NUM_PWR)+1:0]           host_addr,
  input  logic                                 host_we,
  input  logic [DW-1:0]                        host_wdata,
  output logic [DW-1:0]                        host_rdata
);

  localparam int SCH_W = $clog2(NUM_PWR + NUM_TEMP);
  localparam int CH_W  = $clog2(NUM_PWR);
  localparam int AW    = CH_W + telem_pkg::KIND_W;

  logic                          samp_fire;
  logic [NUM_PWR-1:0][DW-1:0]    vpeak_a, vmin_a, ipeak_a;
  logic [NUM_TEMP-1:0][DW-1:0]   tpeak_a;
  logic [NUM_PWR-1:0]            wr_vpeak, wr_vmin, wr_ipeak;
  logic [NUM_TEMP-1:0]           wr_tpeak;

  assign samp_ready = 1'b1;
  assign samp_fire  = samp_valid && samp_ready;

  for (genvar gp = 0; gp < NUM_PWR; gp++) begin : g_pwr
    telem_pwr_lane #(.DW(DW), .SCH_W(SCH_W), .IDX(gp)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_fire (samp_fire),
      .samp_chan (samp_chan),
      .samp_volt (samp_volt),
      .samp_curr (samp_curr),
      .wr_vpeak  (wr_vpeak[gp]),
      .wr_vmin   (wr_vmin[gp]),
      .wr_ipeak  (wr_ipeak[gp]),
      .wdata     (host_wdata),
      .vpeak     (vpeak_a[gp]),
      .vmin      (vmin_a[gp]),
      .ipeak     (ipeak_a[gp])
    );
  end

  for (genvar gt = 0; gt < NUM_TEMP; gt++) begin : g_temp
    telem_temp_lane #(.DW(DW), .SCH_W(SCH_W), .IDX(NUM_PWR + gt)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_fire (samp_fire),
      .samp_chan (samp_chan),
      .samp_temp (samp_temp),
      .wr_tpeak  (wr_tpeak[gt]),
      .wdata     (host_wdata),
      .tpeak     (tpeak_a[gt])
    );
  end

  telem_host_port #(
    .DW(DW), .NUM_PWR(NUM_PWR), .NUM_TEMP(NUM_TEMP), .CH_W(CH_W), .AW(AW)
  ) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .vpeak_a    (vpeak_a),
    .vmin_a     (vmin_a),
    .ipeak_a    (ipeak_a),
    .tpeak_a    (tpeak_a),
    .wr_vpeak   (wr_vpeak),
    .wr_vmin    (wr_vmin),
    .wr_ipeak   (wr_ipeak),
    .wr_tpeak   (wr_tpeak),
    .host_rdata (host_rdata)
  );

endmodule

// File: tb/telem_extreme_tracker_tb.sv
module telem_extreme_tracker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_valid = 1'b0;
  logic        samp_ready;
  logic [4:0]  samp_chan = '0;
  logic [15:0] samp_volt = '0, samp_curr = '0, samp_temp = '0;
  logic [5:0]  host_addr = '0;
  logic        host_we = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural reference state
  logic [15:0] m_vp [16];
  logic [15:0] m_vm [16];
  logic [15:0] m_ip [16];
  logic [15:0] m_tp [5];

  always #4 clk = ~clk;   // 125 MHz

  telem_extreme_tracker u_dut (
    .clk(clk), .rst_n(rst_n),
    .samp_valid(samp_valid), .samp_ready(samp_ready), .samp_chan(samp_chan),
    .samp_volt(samp_volt), .samp_curr(samp_curr), .samp_temp(samp_temp),
    .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_read(logic [5:0] a);
    int c = int'(a[3:0]);
    case (a[5:4])
      2'd0: return m_vp[c];
      2'd1: return m_vm[c];
      2'd2: return m_ip[c];
      default: return (c < 5) ? m_tp[c] : 16'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [5:0] a);
    case (a[5:4])
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return (int'(a[3:0]) < 5) ? "R6" : "R9";
    endcase
  endfunction

  function automatic void m_reset();
    for (int i = 0; i < 16; i++) begin m_vp[i] = 0; m_vm[i] = 16'h7FFF; m_ip[i] = 0; end
    for (int i = 0; i < 5; i++) m_tp[i] = 0;
  endfunction

  // One beat: drive at the falling edge, check the registered read one clock later
  task automatic beat(bit v, int ch, int vo, int cu, int te,
                      bit we, int addr, int wd, string tag);
    logic [15:0] exp;
    string       t;
    samp_valid = v;  samp_chan = 5'(ch);
    samp_volt = 16'(vo); samp_curr = 16'(cu); samp_temp = 16'(te);
    host_we = we; host_addr = 6'(addr); host_wdata = 16'(wd);
    exp = m_read(6'(addr));
    t = (tag != "") ? tag : tag_of(6'(addr));
    if (v) begin
      if (ch < 16) begin
        if (vo != 0) begin
          if (16'(vo) > m_vp[ch]) m_vp[ch] = 16'(vo);
          if (16'(vo) < m_vm[ch]) m_vm[ch] = 16'(vo);
          if (16'(cu) > m_ip[ch]) m_ip[ch] = 16'(cu);
        end
      end else if (ch < 21) begin
        if (16'(te) > m_tp[ch-16]) m_tp[ch-16] = 16'(te);
      end
    end
    if (we) begin
      int c = addr & 15;
      case ((addr >> 4) & 3)
        0: m_vp[c] = 16'(wd);
        1: m_vm[c] = 16'(wd);
        2: m_ip[c] = 16'(wd);
        default: if (c < 5) m_tp[c] = 16'(wd);
      endcase
    end
    @(negedge clk);
    check(t, host_rdata, exp);
  endtask

  task automatic rd(int addr, string tag);
    beat(0, 0, 0, 0, 0, 0, addr, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    check("R1", host_rdata, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {15'h0, samp_ready}, 16'h1);

    // R1: every address after reset
    for (int a = 0; a < 64; a++) rd(a, "R1");
    rd(0, "R1");

    // R2: zero voltage with large current on channel 3
    beat(1, 3, 0, 500, 0, 0, 0, 0, "");
    rd(6'h13, "R2");
    rd(6'h23, "R2");
    rd(6'h03, "R2");

    // R3/R4/R5: unsigned boundary on channel 7
    beat(1, 7, 16'h7FFF, 10, 0, 0, 0, 0, "");
    beat(1, 7, 16'h8000, 5, 0, 0, 0, 0, "");
    rd(6'h07, "R3");
    rd(6'h17, "R4");
    rd(6'h27, "R5");
    beat(1, 7, 16'h0001, 4, 0, 0, 0, 0, "");
    rd(6'h17, "R4");
    rd(6'h27, "R5");

    // R10: update visible one clock after the beat (read issued in the next beat)
    beat(1, 9, 300, 30, 0, 0, 6'h09, 0, "R10");
    rd(6'h09, "R10");

    // R6: temperature channel 17 -> peak 1, zero voltage ignored
    beat(1, 17, 0, 0, 2500, 0, 0, 0, "");
    beat(1, 17, 0, 0, 2400, 0, 0, 0, "");
    rd(6'h31, "R6");
    beat(1, 17, 0, 0, 2600, 0, 0, 0, "");
    rd(6'h31, "R6");

    // R7: host write collides with a sample on the same register
    beat(1, 5, 1000, 900, 0, 1, 6'h05, 16'h0010, "");
    rd(6'h05, "R7");
    rd(6'h15, "R7");

    // R8: write and read same address same cycle returns old, then new
    beat(0, 0, 0, 0, 0, 1, 6'h02, 16'hABCD, "R8");
    rd(6'h02, "R8");

    // R9: out-of-range temperature write, out-of-range sample indices
    beat(0, 0, 0, 0, 0, 1, 6'h39, 16'h1234, "");
    rd(6'h39, "R9");
    for (int ch = 21; ch < 32; ch++) beat(1, ch, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0, 0, 0, "");
    for (int a = 0; a < 64; a++) rd(a, "R9");

    // random mixed traffic, compared every clock
    for (int i = 0; i < 4000; i++) begin
      int vo;
      vo = ($urandom_range(0, 5) == 0) ? 0 : int'($urandom_range(1, 16'hFFFF));
      beat($urandom_range(0, 3) != 0, int'($urandom_range(0, 31)), vo,
           int'($urandom_range(0, 16'hFFFF)), int'($urandom_range(0, 16'hFFFF)),
           $urandom_range(0, 9) == 0, int'($urandom_range(0, 63)),
           int'($urandom_range(0, 16'hFFFF)), "");
      if (samp_ready !== 1'b1) check("R10", {15'h0, samp_ready}, 16'h1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule